// File: doc/BRIEF.md
# Global Reference Association Unit

This block is the tag side of an on-chip chunk store. Chunks are addressed system-wide by 64-bit references that mean the same thing to every activity and process. The block keeps a small fully associative table that records which on-chip slot currently holds which reference. A slot location is given as an access-unit number and a slot index inside that unit. Each slot holds exactly one chunk. The table is never flushed when the running context changes, because its entries are valid for everyone.

Each lookup returns its answer one clock later. A hit reports the slot location. A miss claims a slot for the reference and reports that slot's location. When it claims a slot, the block prefers an empty slot. If every slot is occupied, it takes the least recently used one and raises a write-back strobe carrying the reference being displaced. A release input drops an entry so that its slot can be reused. Moving the chunk data is left to the surrounding logic.

Top module: `gref_assoc`

## Requirements
- R1: After reset every slot is empty, and `rsp_valid` and `wb_valid` are 0.
- R2: A lookup of a stored reference gives `rsp_valid`=1 and `rsp_hit`=1 on the next clock, with the unit and slot where that reference is held.
- R3: A lookup of an absent reference gives `rsp_valid`=1 and `rsp_hit`=0 on the next clock, with the location of the slot now assigned to it. A later lookup of the same reference hits at that location.
- R4: A miss uses an empty slot whenever one exists. Among empty slots, the lowest global index is taken.
- R5: A miss with every slot occupied replaces the least recently used slot. In the same cycle as the response, `wb_valid`=1 and `wb_ref` carries the displaced reference.
- R6: `wb_valid` stays 0 for hits and for misses that land in an empty slot.
- R7: Every hit and every fill makes the touched slot the most recently used. At reset, the recency order runs from global index 0 (newest) to index N-1 (oldest).
- R8: A release of a stored reference empties its slot, so a later lookup of that reference misses. A release of an absent reference changes nothing.
- R9: When a release and a lookup arrive in the same cycle, the release is applied first, and the lookup sees the table without the released entry.
- R10: Global slot index g maps to unit = g / SLOTS_PER_UNIT and slot = g % SLOTS_PER_UNIT. With the defaults, the unit is bit 2 and the slot is bits 1:0 of g.
- R11: A cycle with no lookup gives `rsp_valid`=0 and `wb_valid`=0 on the next clock, and leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ref | input | REF_W | Reference to look up |
| rel_valid | input | 1 | Release request |
| rel_ref | input | REF_W | Reference to release |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | 1 = hit, 0 = slot newly assigned |
| rsp_unit | output | $clog2(UNITS) | Access-unit number of the result |
| rsp_slot | output | $clog2(SLOTS_PER_UNIT) | Slot index within that unit |
| wb_valid | output | 1 | Displaced reference must be written back |
| wb_ref | output | REF_W | Displaced reference |

## Verification
Release and lookup can land in the same cycle. The outcome depends on whether the release comes first.

The bench provokes this in two ways. It releases the reference being looked up in that very cycle. It also releases another entry of a full table while a new reference misses. In the first case the lookup must miss. In the second it must take the freed slot with no write-back.

The random phase draws both requests from a small pool of references, so such collisions happen often. A bench model that applies the release first and then the lookup judges every response and every write-back.

// File: rtl/gref_pkg.sv
package gref_pkg;

  // Outcome of a lookup cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_HIT  = 2'd1,
    OP_FILL = 2'd2
  } gref_op_e;

endpackage

// File: rtl/gref_free_pick.sv
// Lowest-index set bit of a vector, plus an any-set flag.
module gref_free_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/gref_tag_cam.sv
// Reference tags with per-slot valid bits. Release is applied ahead of the
// lookup compare within the same cycle.
module gref_tag_cam #(
  parameter int REF_W = 64,
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] look_ref,
  input  logic             rel_valid,
  input  logic [REF_W-1:0] rel_ref,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REF_W-1:0] wr_ref,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [N-1:0]     hit_vec,
  output logic [N-1:0]     valid_post,
  output logic [REF_W-1:0] rd_ref
);

  logic [REF_W-1:0] tag_q [N];
  logic [N-1:0]     valid_q;
  logic [N-1:0]     rel_hit;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign rel_hit[g]    = rel_valid && valid_q[g] && (tag_q[g] == rel_ref);
      assign valid_post[g] = valid_q[g] && !rel_hit[g];
      assign hit_vec[g]    = valid_post[g] && (tag_q[g] == look_ref);
    end
  endgenerate

  assign rd_ref = tag_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_post;
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  // R2: no reference is ever stored in two slots
  a_r2_unique_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R3: a written slot is occupied on the following cycle
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/gref_age_lru.sv
// Per-slot age counters forming a permutation of 0..N-1; age 0 is newest.
module gref_age_lru #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     is_oldest;

  generate
    for (genvar g = 0; g < N; g++) begin : g_age
      assign is_oldest[g] = (age_q[g] == OLDEST);

      always_ff @(posedge clk) begin
        if (rst) begin
          age_q[g] <= IDX_W'(g);
        end else if (touch_en) begin
          if (IDX_W'(g) == touch_idx)
            age_q[g] <= '0;
          else if (age_q[g] < age_q[touch_idx])
            age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  endgenerate

  gref_free_pick #(.N(N), .IDX_W(IDX_W)) i_oldest_pick (
    .vec (is_oldest),
    .any (),
    .idx (lru_idx)
  );

  // R7: exactly one slot holds the oldest age at all times
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(is_oldest) == 1);

  // R11: without a touch, the recency order is frozen
  a_r11_age_stable: assert property (@(posedge clk) disable iff (rst)
    !touch_en |=> $stable(lru_idx));

endmodule

// File: rtl/gref_assoc.sv
module gref_assoc #(
  parameter int REF_W          = 64,
  parameter int UNITS          = 2,
  parameter int SLOTS_PER_UNIT = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [REF_W-1:0]                  req_ref,
  input  logic                              rel_valid,
  input  logic [REF_W-1:0]                  rel_ref,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [$clog2(UNITS)-1:0]          rsp_unit,
  output logic [$clog2(SLOTS_PER_UNIT)-1:0] rsp_slot,
  output logic                              wb_valid,
  output logic [REF_W-1:0]                  wb_ref
);
  import gref_pkg::*;

  localparam int N      = UNITS * SLOTS_PER_UNIT;
  localparam int UNIT_W = $clog2(UNITS);
  localparam int SLOT_W = $clog2(SLOTS_PER_UNIT);
  localparam int IDX_W  = UNIT_W + SLOT_W;

  logic [N-1:0]     hit_vec, valid_post, free_vec;
  logic             hit_any, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, alloc_idx, touch_idx;
  logic [REF_W-1:0] victim_ref;
  logic             evict;
  gref_op_e         op;

  assign free_vec = ~valid_post;

  gref_tag_cam #(.REF_W(REF_W), .N(N), .IDX_W(IDX_W)) i_cam (
    .clk        (clk),
    .rst        (rst),
    .look_ref   (req_ref),
    .rel_valid  (rel_valid),
    .rel_ref    (rel_ref),
    .wr_en      (op == OP_FILL),
    .wr_idx     (alloc_idx),
    .wr_ref     (req_ref),
    .rd_idx     (alloc_idx),
    .hit_vec    (hit_vec),
    .valid_post (valid_post),
    .rd_ref     (victim_ref)
  );

  gref_free_pick #(.N(N), .IDX_W(IDX_W)) i_hit_enc (
    .vec (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  gref_free_pick #(.N(N), .IDX_W(IDX_W)) i_free_pick (
    .vec (free_vec),
    .any (free_any),
    .idx (free_idx)
  );

  gref_age_lru #(.N(N), .IDX_W(IDX_W)) i_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (op != OP_IDLE),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  always_comb begin
    if (!req_valid)   op = OP_IDLE;
    else if (hit_any) op = OP_HIT;
    else              op = OP_FILL;
  end

  assign alloc_idx = free_any ? free_idx : lru_idx;
  assign touch_idx = (op == OP_HIT) ? hit_idx : alloc_idx;
  assign evict     = (op == OP_FILL) && !free_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_unit  <= '0;
      rsp_slot  <= '0;
      wb_valid  <= 1'b0;
      wb_ref    <= '0;
    end else begin
      rsp_valid <= (op != OP_IDLE);
      wb_valid  <= evict;
      if (op != OP_IDLE) begin
        rsp_hit  <= (op == OP_HIT);
        rsp_unit <= touch_idx[IDX_W-1:SLOT_W];
        rsp_slot <= touch_idx[SLOT_W-1:0];
      end
      if (evict) wb_ref <= victim_ref;
    end
  end

  // R5: a write-back only accompanies a miss response
  a_r5_wb_on_miss: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_hit));

  // R11: a response exists only for a lookup in the previous cycle
  a_r11_rsp_needs_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  // R4: a displacement happens only when no slot was free
  a_r4_evict_only_full: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit_any && free_any) |=> !wb_valid);

endmodule

// File: tb/test_gref_assoc.sv
`timescale 1ns/100ps
module test_gref_assoc;

  localparam int N   = 8;
  localparam int SPU = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, rel_valid;
  logic [63:0] req_ref, rel_ref;
  logic        rsp_valid, rsp_hit, wb_valid;
  logic [0:0]  rsp_unit;
  logic [1:0]  rsp_slot;
  logic [63:0] wb_ref;

  always #2.5 clk = ~clk;

  gref_assoc #(.REF_W(64), .UNITS(2), .SLOTS_PER_UNIT(SPU)) i_gref_assoc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ref(req_ref),
    .rel_valid(rel_valid), .rel_ref(rel_ref), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_unit(rsp_unit), .rsp_slot(rsp_slot),
    .wb_valid(wb_valid), .wb_ref(wb_ref)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [63:0] m_tag [N];
  bit          m_val [N];
  int          m_stamp [N];
  int          now;
  logic [63:0] pool [12];

  // results of the last operation, for directed checks
  int last_idx;
  bit last_hit;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_stamp[i] = N - 1 - i; m_tag[i] = '0;
    end
    now = N;
  endtask

  // release first, then lookup (R9)
  task automatic do_op(bit rq, logic [63:0] r, bit rl, logic [63:0] rr);
    bit e_hit, e_wb, full;
    int idx;
    logic [63:0] e_wbref;
    string tag;
    e_hit = 0; e_wb = 0; idx = -1; e_wbref = '0;
    if (rl)
      for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == rr) m_val[i] = 0;
    if (rq) begin
      for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == r) begin e_hit = 1; idx = i; end
      if (!e_hit) begin
        for (int i = N - 1; i >= 0; i--) if (!m_val[i]) idx = i;
        full = (idx < 0);
        if (full) begin
          idx = 0;
          for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[idx]) idx = i;
          e_wb = 1; e_wbref = m_tag[idx];
        end
        m_tag[idx] = r; m_val[idx] = 1;
      end
      m_stamp[idx] = ++now;
    end
    req_valid = rq; req_ref = r; rel_valid = rl; rel_ref = rr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    last_idx = idx; last_hit = e_hit;
    tag = !rq ? "R11" : e_hit ? "R2" : e_wb ? "R5" : "R4";
    check(rsp_valid == rq, rq ? "R2/R3 rsp_valid" : "R11 rsp_valid", 64'(rsp_valid), 64'(rq));
    if (rq) begin
      check(rsp_hit == e_hit, e_hit ? "R2 hit" : "R3 miss", 64'(rsp_hit), 64'(e_hit));
      check({rsp_unit, rsp_slot} == 3'(idx), {tag, " R10 location"},
            64'({rsp_unit, rsp_slot}), 64'(idx));
    end
    check(wb_valid == e_wb, e_wb ? "R5 wb_valid" : "R6 wb_valid", 64'(wb_valid), 64'(e_wb));
    if (e_wb) check(wb_ref == e_wbref, "R5 wb_ref", wb_ref, e_wbref);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 12; i++) pool[i] = {$urandom, $urandom};
    req_valid = 0; rel_valid = 0; req_ref = '0; rel_ref = '0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(rsp_valid == 0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
    check(wb_valid == 0, "R1 wb_valid after reset", 64'(wb_valid), 0);

    // R1 R4 R10: fills land in index order 0..7
    for (int i = 0; i < N; i++) begin
      do_op(1, pool[i], 0, '0);
      check(last_idx == i, "R4 empty slot order", 64'(last_idx), 64'(i));
    end
    check(rsp_unit == 1 && rsp_slot == 3, "R10 unit/slot of index 7",
          64'({rsp_unit, rsp_slot}), 64'(7));
    // R2 R7: hit slot 0 so slot 1 becomes oldest
    do_op(1, pool[0], 0, '0);
    do_op(1, pool[8], 0, '0);
    check(last_idx == 1, "R7 LRU victim after hit", 64'(last_idx), 1);
    // R11 idle cycle
    do_op(0, '0, 0, '0);
    // R8: release slot 3, next miss takes it without write-back
    do_op(0, '0, 1, pool[3]);
    do_op(1, pool[9], 0, '0);
    check(last_idx == 3 && !wb_valid, "R8 released slot reused", 64'(last_idx), 3);
    // R8: release of absent reference changes nothing
    do_op(0, '0, 1, 64'hDEAD_0000_BEEF_0001);
    do_op(1, pool[2], 0, '0);
    check(last_hit && rsp_hit, "R8 absent release no effect", 64'(rsp_hit), 1);
    // R9: release and lookup of the same reference in one cycle
    do_op(1, pool[4], 1, pool[4]);
    check(!rsp_hit && !wb_valid && last_idx == 4, "R9 release before lookup",
          64'({rsp_hit, wb_valid}), 0);
    // R9: full table, release other entry while new one misses
    do_op(1, pool[10], 1, pool[5]);
    check(!wb_valid && last_idx == 5, "R9 freed slot used same cycle",
          64'(last_idx), 5);
    // R8: released reference now misses
    do_op(1, pool[3], 0, '0);
    check(!rsp_hit, "R8 released ref misses", 64'(rsp_hit), 0);

    // random phase
    for (int k = 0; k < 800; k++) begin
      do_op(($urandom % 5) != 0, pool[$urandom % 12],
            ($urandom % 4) == 0, pool[$urandom % 12]);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule